// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs the external bus cycles of a processor-style interface. Address and data share one set of sixteen pins, and a wider address bus without multiplexing runs beside them. The core presents a request with an address, write data, byte enables and a direction. The sequencer then takes the bus through four bus states. In the first state the shared pins carry the address. In the next three states they carry write data, or they float so that the system can return read data. Read data is captured at the end of the third state. A done pulse is given in the fourth state.

The block also handles several side modes. A bus-hold request from another master floats every output. Reset floats every output too. A show-read mode copies internal memory reads onto the pins in the last two states, so that an external observer can see them. An address-phase suppression option leaves the shared pins floating in the first state. Straps are captured while reset is held. The parameter `NARROW` selects one of two pin layouts: a 16-bit data path, or an 8-bit data path in which the upper byte of the pins carries address only. The pins are split into output, output-enable and input vectors; the pad ring joins them. The FSM states are IDLE, T1, T2, T3, T4 and HOLD. Its transitions are IDLE to T1 on an accepted request, IDLE to HOLD on a hold request, HOLD to IDLE when the hold request is removed, T1 to T2 to T3 to T4 unconditionally, and T4 to IDLE.

Top module: `muxbus_seq`

## Requirements
- R1: A request is accepted at a rising edge when `req_ready` is high, where `req_ready` = reset released, state IDLE and `hold_req` low. The bus then passes through exactly T1, T2, T3 and T4, one clock each, and returns to IDLE.
- R2: In T1 the shared pins drive `req_addr[15:0]`. `ad_oe` bit 0 enables `ad_out[7:0]` and bit 1 enables `ad_out[15:8]`, and both bits are set.
- R3: On a write, in T2, T3 and T4, each lane whose byte enable is set drives its byte of `req_wdata`. `req_be[0]` belongs to the low lane and `req_be[1]` to the high lane. A lane whose enable is clear has its `ad_oe` bit at 0.
- R4: On a read that is not shown, `ad_oe` is 0 in T2 to T4. `rdata` takes `ad_in` as sampled at the edge that ends T3. `done` is high for the whole T4 cycle and for no other cycle, and `rdata` holds its value until the next read.
- R5: `a_oe` rises and `a_out` takes `req_addr` at the falling edge inside the IDLE cycle in which a request is offered and can be accepted. This is half a clock before the address reaches the shared pins. Both stay unchanged through T4, and `a_oe` drops at the next falling edge in IDLE that has no acceptable request.
- R6: `hold_req` seen in IDLE moves the FSM to HOLD. `hold_req` wins over a pending request. In HOLD `hold_ack` is 1, `ad_oe` is 0, `a_oe` is 0 and no request is accepted. The FSM returns to IDLE one clock after `hold_req` falls. A hold that is raised during a cycle waits until T4 has ended.
- R7: While `rst_n` is low, `ad_oe` is 0, `a_oe` is 0, `done` is 0 and `rdata` is 0. After reset the FSM starts in IDLE.
- R8: A request is shown if `show_read` is 1 when it is accepted, or if `show_strap_n` was 0 in the last reset cycle. For a shown internal read (`req_internal`=1, `req_write`=0), the enabled lanes drive `req_wdata` in T3 and T4 only. Any internal read returns `req_wdata` in `rdata`.
- R9: If `addr_phase_off` is 1 when a request is accepted, the shared lanes stay floating in T1, and the cycle still lasts four states.
- R10: With `NARROW`=1, `ad_out[15:8]` carries `req_addr[15:8]` and `ad_oe[1]` is 1 from T1 to T4, whatever the byte enables or the address-phase option. Only the low lane carries data, and `rdata[15:8]` is 0.
- R11: `cfg_word` equals `ad_in` as sampled in the last clock with `rst_n` low. It then holds that value until the next reset.
- R12: `status_lock` is 1 exactly when `aden_strap_n` was 0 in the last clock with `rst_n` low. It keeps that value until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_internal | input | 1 | Read targets internal memory |
| req_addr | input | 20 | Request address |
| req_wdata | input | 16 | Write data, or internal read data |
| req_be | input | 2 | Byte enables, bit 0 = low lane |
| req_ready | output | 1 | A request offered now will be accepted |
| show_read | input | 1 | Control bit that shows internal reads |
| addr_phase_off | input | 1 | Suppress the T1 address on the shared pins |
| hold_req | input | 1 | External bus-hold request |
| hold_ack | output | 1 | Bus released (HOLD state) |
| a_out | output | 20 | Address bus without multiplexing |
| a_oe | output | 1 | Output enable of `a_out` |
| ad_out | output | 16 | Shared pins, output value |
| ad_oe | output | 2 | Per-lane output enable of the shared pins |
| ad_in | input | 16 | Shared pins, input value |
| rdata | output | 16 | Read data returned to the core |
| done | output | 1 | Cycle completion (T4) |
| show_strap_n | input | 1 | Show-read strap, active low |
| aden_strap_n | input | 1 | Status-lock strap, active low |
| cfg_word | output | 16 | Configuration captured at reset |
| status_lock | output | 1 | Status pins locked to normal function |

## Verification
The shared-pin outputs follow the state register directly. Their expected values therefore change one rising edge after an accepted request, and then at every later edge. `a_out` and `a_oe` change on the falling edge, half a clock earlier than the shared pins. `rdata` is loaded on the edge that ends T3, so its new value, together with `done`, is due in the T4 cycle. `cfg_word` and `status_lock` reflect the last rising edge taken with reset low. The bench steps its behavioural model once per rising edge. It compares every output 5 ns after each falling edge, which is after both kinds of register have settled and before any input changes.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_T4,
        ST_HOLD
    } bus_st_e;

    typedef struct packed {
        logic              write;
        logic              internal;
        logic              show;
        logic              addr_off;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  be;
    } bus_req_t;
endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
    import mbs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    hold_req,
    output bus_st_e state,
    output logic    ready,
    output logic    accept
);
    bus_st_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        ready  = rst_n && (state == ST_IDLE) && !hold_req;
        accept = ready && req_valid;
        nxt    = state;
        unique case (state)
            ST_IDLE: begin
                if (hold_req)       nxt = ST_HOLD;
                else if (req_valid) nxt = ST_T1;
            end
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3:   nxt = ST_T4;
            ST_T4:   nxt = ST_IDLE;
            ST_HOLD: if (!hold_req) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // R1: the four bus states follow one another without a gap
    a_r1_t1_to_t2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_T1 |=> state == ST_T2);
    a_r1_t3_to_t4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_T3 |=> state == ST_T4);
    a_r1_t4_exit: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_T4 |=> state == ST_IDLE);
    // R6: hold is kept while it is requested
    a_r6_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && hold_req) |=> state == ST_HOLD);
endmodule

// File: rtl/mbs_lane.sv
module mbs_lane
    import mbs_pkg::*;
#(
    parameter bit NARROW = 1'b0,
    parameter int LANE   = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  bus_st_e    state,
    input  bus_req_t   req,
    output logic [7:0] lane_out,
    output logic       lane_oe
);
    localparam bit ADDR_ONLY = NARROW && (LANE == 1);
    localparam int LO = LANE * 8;

    logic drive_data;

    always_comb begin
        lane_out   = '0;
        lane_oe    = 1'b0;
        drive_data = req.write || (req.show && req.internal);
        if (ADDR_ONLY) begin
            lane_out = req.addr[LO +: 8];
            lane_oe  = state inside {ST_T1, ST_T2, ST_T3, ST_T4};
        end else begin
            unique case (state)
                ST_T1: begin
                    lane_out = req.addr[LO +: 8];
                    lane_oe  = !req.addr_off;
                end
                ST_T2: begin
                    lane_out = req.data[LO +: 8];
                    lane_oe  = req.write && req.be[LANE];
                end
                ST_T3, ST_T4: begin
                    lane_out = req.data[LO +: 8];
                    lane_oe  = drive_data && req.be[LANE];
                end
                default: begin
                    lane_out = '0;
                    lane_oe  = 1'b0;
                end
            endcase
        end
    end

    if (!ADDR_ONLY) begin : g_chk
        // R4: a read leaves the lane floating in T2
        a_r4_t2_read_float: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_T2 && !req.write) |-> !lane_oe);
    end else begin : g_chk_ao
        // R10: address-only lane is driven through the whole cycle
        a_r10_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_T4) |-> lane_oe);
    end
endmodule

// File: rtl/mbs_strap.sv
module mbs_strap
    import mbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad_in,
    input  logic              show_strap_n,
    input  logic              aden_strap_n,
    output logic [DATA_W-1:0] cfg_word,
    output logic              show_strap_on,
    output logic              status_lock
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_word      <= ad_in;
            show_strap_on <= !show_strap_n;
            status_lock   <= !aden_strap_n;
        end
    end

    // R11: configuration is frozen once reset is released
    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_word));
endmodule

// File: rtl/muxbus_seq.sv
module muxbus_seq
    import mbs_pkg::*;
#(
    parameter bit NARROW = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_internal,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              req_ready,
    input  logic              show_read,
    input  logic              addr_phase_off,
    input  logic              hold_req,
    output logic              hold_ack,
    output logic [ADDR_W-1:0] a_out,
    output logic              a_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic [LANES-1:0]  ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    input  logic              show_strap_n,
    input  logic              aden_strap_n,
    output logic [DATA_W-1:0] cfg_word,
    output logic              status_lock
);
    localparam logic [DATA_W-1:0] RD_MASK = NARROW ? DATA_W'(8'hFF) : '1;

    bus_st_e  state;
    logic     accept;
    logic     show_strap_on;
    bus_req_t req_q;

    mbs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .hold_req  (hold_req),
        .state     (state),
        .ready     (req_ready),
        .accept    (accept)
    );

    mbs_strap u_strap (
        .clk           (clk),
        .rst_n         (rst_n),
        .ad_in         (ad_in),
        .show_strap_n  (show_strap_n),
        .aden_strap_n  (aden_strap_n),
        .cfg_word      (cfg_word),
        .show_strap_on (show_strap_on),
        .status_lock   (status_lock)
    );

    always_ff @(posedge clk) begin
        if (accept) begin
            req_q.write    <= req_write;
            req_q.internal <= req_internal;
            req_q.show     <= show_read || show_strap_on;
            req_q.addr_off <= addr_phase_off;
            req_q.addr     <= req_addr;
            req_q.data     <= req_wdata;
            req_q.be       <= req_be;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (state == ST_T3 && !req_q.write)
            rdata <= (req_q.internal ? req_q.data : ad_in) & RD_MASK;
    end

    always_ff @(negedge clk) begin
        if (!rst_n) begin
            a_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    a_oe <= accept;
                    if (accept) a_out <= req_addr;
                end
                ST_HOLD: a_oe <= 1'b0;
                default: a_oe <= a_oe;
            endcase
        end
    end

    always_comb begin
        done     = (state == ST_T4);
        hold_ack = (state == ST_HOLD);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        mbs_lane #(.NARROW(NARROW), .LANE(g)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .state    (state),
            .req      (req_q),
            .lane_out (ad_out[g*8 +: 8]),
            .lane_oe  (ad_oe[g])
        );
    end

    // R6: nothing is driven while another master owns the bus
    a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (ad_oe == '0 && !a_oe));
    // R5: the plain address is valid whenever the shared pins drive
    a_r5_addr_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe != '0) |-> a_oe);
    // R4: done lasts one cycle
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/test_muxbus_seq.sv
module test_muxbus_seq;
    localparam int AW = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_internal = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        show_read = 1'b0, addr_phase_off = 1'b0, hold_req = 1'b0;
    logic [15:0] ad_in = 16'hA5C3;
    logic        show_strap_n = 1'b1, aden_strap_n = 1'b0;

    logic        rdy [2];
    logic        hack[2];
    logic [19:0] aout[2];
    logic        aoe [2];
    logic [15:0] adout[2];
    logic [1:0]  adoe[2];
    logic [15:0] rd  [2];
    logic        dn  [2];
    logic [15:0] cfg [2];
    logic        lck [2];

    muxbus_seq #(.NARROW(1'b0)) i_muxbus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_internal(req_internal), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .req_ready(rdy[0]), .show_read(show_read),
        .addr_phase_off(addr_phase_off), .hold_req(hold_req), .hold_ack(hack[0]),
        .a_out(aout[0]), .a_oe(aoe[0]), .ad_out(adout[0]), .ad_oe(adoe[0]),
        .ad_in(ad_in), .rdata(rd[0]), .done(dn[0]), .show_strap_n(show_strap_n),
        .aden_strap_n(aden_strap_n), .cfg_word(cfg[0]), .status_lock(lck[0]));

    muxbus_seq #(.NARROW(1'b1)) i_muxbus_seq_nar (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_internal(req_internal), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .req_ready(rdy[1]), .show_read(show_read),
        .addr_phase_off(addr_phase_off), .hold_req(hold_req), .hold_ack(hack[1]),
        .a_out(aout[1]), .a_oe(aoe[1]), .ad_out(adout[1]), .ad_oe(adoe[1]),
        .ad_in(ad_in), .rdata(rd[1]), .done(dn[1]), .show_strap_n(show_strap_n),
        .aden_strap_n(aden_strap_n), .cfg_word(cfg[1]), .status_lock(lck[1]));

    always #10 clk = ~clk;

    int vectors = 0;
    int errors  = 0;

    // behavioural model: 0 idle, 1..4 bus states, 5 hold
    int          m_st = 0;
    bit          m_wr, m_int, m_show, m_off;
    logic [19:0] m_addr;
    logic [15:0] m_data;
    logic [1:0]  m_be;
    logic [15:0] m_rd[2] = '{16'h0, 16'h0};
    logic [15:0] m_cfg;
    bit          m_sstr, m_lock;

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string lane_req(input int n, input int l);
        if (!rst_n)              return "R7";
        if (m_st == 5)           return "R6";
        if (n == 1 && l == 1)    return "R10";
        if (m_st == 1)           return m_off ? "R9" : "R2";
        if (m_wr)                return "R3";
        if (m_int && m_show)     return "R8";
        return "R4";
    endfunction

    task automatic compare();
        for (int n = 0; n < 2; n++) begin
            bit          acc;
            logic [15:0] eo;
            logic [1:0]  eoe;
            acc = rst_n && m_st == 0 && !hold_req && req_valid;
            check("R1", "req_ready", 32'(rdy[n]), 32'(rst_n && m_st == 0 && !hold_req));
            check("R6", "hold_ack", 32'(hack[n]), 32'(m_st == 5));
            check("R4", "done", 32'(dn[n]), 32'(m_st == 4));
            check(m_int ? "R8" : "R4", "rdata", 32'(rd[n]), 32'(m_rd[n]));
            check("R11", "cfg_word", 32'(cfg[n]), 32'(m_cfg));
            check("R12", "status_lock", 32'(lck[n]), 32'(m_lock));
            if (!rst_n || m_st == 5 || (m_st == 0 && !acc)) begin
                check(rst_n ? "R5" : "R7", "a_oe", 32'(aoe[n]), 32'h0);
            end else begin
                check("R5", "a_oe", 32'(aoe[n]), 32'h1);
                check("R5", "a_out", 32'(aout[n]), 32'(acc ? req_addr : m_addr));
            end
            for (int l = 0; l < 2; l++) begin
                eoe[l] = 1'b0;
                eo[l*8 +: 8] = 8'h00;
                if (rst_n && m_st >= 1 && m_st <= 4) begin
                    if (n == 1 && l == 1) begin
                        eoe[l] = 1'b1; eo[l*8 +: 8] = m_addr[15:8];
                    end else if (m_st == 1) begin
                        eoe[l] = !m_off; eo[l*8 +: 8] = m_addr[l*8 +: 8];
                    end else if (m_wr || (m_st >= 3 && m_int && m_show)) begin
                        eoe[l] = m_be[l]; eo[l*8 +: 8] = m_data[l*8 +: 8];
                    end
                end
                check(lane_req(n, l), "ad_oe", 32'(adoe[n][l]), 32'(eoe[l]));
                if (eoe[l])
                    check(lane_req(n, l), "ad_out", 32'(adout[n][l*8 +: 8]),
                          32'(eo[l*8 +: 8]));
            end
        end
    endtask

    task automatic advance();
        if (!rst_n) begin
            m_st = 0; m_rd[0] = 0; m_rd[1] = 0;
            m_cfg = ad_in; m_sstr = !show_strap_n; m_lock = !aden_strap_n;
            return;
        end
        case (m_st)
            0: if (hold_req) m_st = 5;
               else if (req_valid) begin
                   m_wr = req_write; m_int = req_internal; m_off = addr_phase_off;
                   m_show = show_read || m_sstr; m_addr = req_addr;
                   m_data = req_wdata; m_be = req_be; m_st = 1;
               end
            3: begin
                   if (!m_wr) begin
                       m_rd[0] = m_int ? m_data : ad_in;
                       m_rd[1] = m_rd[0] & 16'h00FF;
                   end
                   m_st = 4;
               end
            4: m_st = 0;
            5: if (!hold_req) m_st = 0;
            default: m_st = m_st + 1;
        endcase
    endtask

    initial begin
        advance();
        forever begin
            @(posedge clk);
            @(negedge clk);
            #5;
            compare();
            advance();
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic bus(input bit wr, input bit intl, input logic [19:0] a,
                       input logic [15:0] d, input logic [1:0] be, input int gap);
        req_valid = 1'b1; req_write = wr; req_internal = intl;
        req_addr = a; req_wdata = d; req_be = be;
        step(1);
        req_valid = 1'b0;
        step(gap);
    endtask

    initial begin
        // R7 R11 R12: reset state and strap capture
        step(3);
        rst_n = 1'b1;
        ad_in = 16'h1111;
        step(2);
        // R1 R2 R3 R5: full write
        bus(1, 0, 20'h3_1234, 16'hBEEF, 2'b11, 6);
        // R3: single lanes
        bus(1, 0, 20'h0_00A1, 16'h1357, 2'b01, 5);
        bus(1, 0, 20'h0_00A2, 16'h2468, 2'b10, 5);
        // R4: external read
        ad_in = 16'h5A69;
        bus(0, 0, 20'h7_4000, 16'h0000, 2'b11, 6);
        ad_in = 16'h0F0F;
        step(2);
        // R9: address phase suppressed
        addr_phase_off = 1'b1;
        bus(1, 0, 20'h2_2222, 16'hC0DE, 2'b11, 6);
        addr_phase_off = 1'b0;
        // R6: hold wins over a pending request
        hold_req = 1'b1; req_valid = 1'b1; req_addr = 20'h5_5555;
        step(4);
        hold_req = 1'b0;
        step(6);
        req_valid = 1'b0;
        step(2);
        // R6: hold raised inside a cycle waits for T4
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h6_0001; req_wdata = 16'h4242;
        step(1);
        req_valid = 1'b0; hold_req = 1'b1;
        step(7);
        hold_req = 1'b0;
        step(2);
        // R8: shown internal read through the control bit, then unshown
        show_read = 1'b1;
        bus(0, 1, 20'h0_0100, 16'h9ABC, 2'b11, 6);
        show_read = 1'b0;
        bus(0, 1, 20'h0_0102, 16'h7777, 2'b11, 6);
        // R1: back-to-back reads
        ad_in = 16'h3C3C;
        req_valid = 1'b1; req_write = 1'b0; req_internal = 1'b0; req_addr = 20'h1_0F00;
        step(10);
        req_valid = 1'b0;
        step(3);
        // R11 R12 R8: second reset with other straps, show via strap
        rst_n = 1'b0; show_strap_n = 1'b0; aden_strap_n = 1'b1; ad_in = 16'hE718;
        step(2);
        rst_n = 1'b1; ad_in = 16'h0000;
        step(2);
        bus(0, 1, 20'h0_0200, 16'h55AA, 2'b01, 6);
        bus(0, 0, 20'h0_0300, 16'h0000, 2'b11, 6);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule